// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block is the interrupt logic of a three-channel serial receive/transmit controller. Each channel raises single-cycle event pulses for four causes: receive data ready, receive wrong parity, transmit end-of-transmission and transmit FIFO empty. Each pulse sets a sticky status bit. A mask register decides which status bits drive the interrupt request line.

When the host acknowledges an interrupt, the block chooses the highest-priority enabled source and latches a vector. The vector is the upper part of a host-written base with a four-bit source code in its low nibble. Wrong-parity reporting only works while a self-test bit is set. Those status bits are cleared through their own address, so the ordinary status clear cannot remove them.

The order among data-ready sources can be rotated. Status, mask, base, rotation and self-test registers sit behind a simple synchronous register port.

Top module: `ivc_top`

## Requirements
- R1: After reset: status, mask, rotation and self-test all read 0, `irq_o` is low and `vector_o` is 0x0F.
- R2: A pulse on an event input sets status bit `4*ch + cause`, where the cause codes are 0 = data ready, 1 = wrong parity, 2 = end of transmission and 3 = FIFO empty. The bit stays set until it is cleared. If an event and a clear hit the same bit in the same cycle, the event wins.
- R3: The mask register is at address 1 and uses the status bit layout. `irq_o` is high exactly when some status bit is set and its mask bit is 1.
- R4: Writing to address 0 clears every data-ready, end-of-transmission and FIFO-empty status bit whose write-data bit is 1. Wrong-parity bits are left unchanged by this write.
- R5: A wrong-parity event sets its status bit only while self-test bit 0 (address 4) is 1. Wrong-parity bits are cleared only by writing 1s to address 5, using the status bit positions.
- R6: On `iack_i` the block latches `{base[7:4], ch[1:0], cause[1:0]}` of the winning source into `vector_o`, and the value then holds until the next acknowledge. If no enabled source is pending at the acknowledge, the low nibble is 0xF.
- R7: The base register at address 2 is write-only and reads as 0. Until it has been written, every acknowledge returns 0x0F.
- R8: Priority runs from highest to lowest as follows: wrong parity (channel 0, 1, 2), then data ready in the rotated order, then end of transmission (channel 0, 1, 2), then FIFO empty (channel 0, 1, 2). Masked bits never win.
- R9: Bits [1:0] of the rotation register at address 3 give the first channel in the data-ready order. A value of r = 0..2 gives the order r, r+1, ... wrapping round the channels. A value of 3 behaves like 0.
- R10: Reads of addresses 0, 1, 3 and 4 return status, mask, rotation and self-test. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ready_i | input | 3 | Data-ready event pulse, one bit per channel |
| rx_perr_i | input | 3 | Wrong-parity event pulse, one bit per channel |
| tx_eot_i | input | 3 | End-of-transmission event pulse, one bit per channel |
| tx_empty_i | input | 3 | FIFO-empty event pulse, one bit per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| vector_o | output | 8 | Latched interrupt vector |

## Verification
Some rules are checked by the assertions on every cycle. A wrong-parity bit only appears after a cycle with self-test on, and it only drops after a write to its own clear address. Other status bits only drop after a status clear. The arbiter grants at most one pending source, and wrong parity beats everything else. The vector holds between acknowledges and stays at 0x0F until a base is written.

Some behaviour can only be shown by the bench's scenarios: the actual vector codes for each mix of pending events, mask patterns and rotation settings, the register read-back, and the event-beats-clear collision.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int CAUSES = 4;

    typedef enum logic [1:0] {
        CA_READY = 2'd0,
        CA_PERR  = 2'd1,
        CA_EOT   = 2'd2,
        CA_EMPTY = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_MASK   = 3'd1,
        RA_BASE   = 3'd2,
        RA_ROT    = 3'd3,
        RA_TEST   = 3'd4,
        RA_PCLR   = 3'd5
    } regaddr_e;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
    import ivc_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 12,
    parameter int VW  = 8,
    localparam int NSRC = NCH * CAUSES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ev_ready,
    input  logic [NCH-1:0]  ev_perr,
    input  logic [NCH-1:0]  ev_eot,
    input  logic [NCH-1:0]  ev_empty,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] mask_o,
    output logic [VW-5:0]   base_hi_o,
    output logic            base_set_o,
    output logic [1:0]      rot_o
);
    function automatic logic [NSRC-1:0] perr_positions();
        logic [NSRC-1:0] p;
        p = '0;
        for (int c = 0; c < NCH; c++) p[c*CAUSES + int'(CA_PERR)] = 1'b1;
        return p;
    endfunction

    localparam logic [NSRC-1:0] PERR_POS = perr_positions();

    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] mask;
        logic [VW-5:0]   base_hi;
        logic            base_set;
        logic [1:0]      rot;
        logic            test;
    } regs_s;

    regs_s r_d, r_q;
    logic [NSRC-1:0] set_v, clr_v;

    always_comb begin
        r_d   = r_q;
        set_v = '0;
        clr_v = '0;
        for (int c = 0; c < NCH; c++) begin
            set_v[c*CAUSES + int'(CA_READY)] = ev_ready[c];
            set_v[c*CAUSES + int'(CA_PERR)]  = ev_perr[c] & r_q.test;
            set_v[c*CAUSES + int'(CA_EOT)]   = ev_eot[c];
            set_v[c*CAUSES + int'(CA_EMPTY)] = ev_empty[c];
        end
        if (wr_en) begin
            case (regaddr_e'(addr))
                RA_STATUS: clr_v = wdata[NSRC-1:0] & ~PERR_POS;
                RA_PCLR:   clr_v = wdata[NSRC-1:0] & PERR_POS;
                RA_MASK:   r_d.mask = wdata[NSRC-1:0];
                RA_BASE: begin
                    r_d.base_hi  = wdata[VW-1:4];
                    r_d.base_set = 1'b1;
                end
                RA_ROT:    r_d.rot  = wdata[1:0];
                RA_TEST:   r_d.test = wdata[0];
                default: ;
            endcase
        end
        r_d.status = (r_q.status & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (regaddr_e'(addr))
            RA_STATUS: rdata[NSRC-1:0] = r_q.status;
            RA_MASK:   rdata[NSRC-1:0] = r_q.mask;
            RA_ROT:    rdata[1:0]      = r_q.rot;
            RA_TEST:   rdata[0]        = r_q.test;
            default: ;
        endcase
    end

    assign status_o   = r_q.status;
    assign mask_o     = r_q.mask;
    assign base_hi_o  = r_q.base_hi;
    assign base_set_o = r_q.base_set;
    assign rot_o      = r_q.rot;

    AST_PERR_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.status & PERR_POS & ~$past(r_q.status))) |-> $past(r_q.test)); // R5

    AST_PERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(r_q.status) & PERR_POS & ~r_q.status))
        |-> $past(wr_en && addr == 3'(RA_PCLR))); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(r_q.status) & ~PERR_POS & ~r_q.status))
        |-> $past(wr_en && addr == 3'(RA_STATUS))); // R4

    AST_BASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.base_set) |-> $past(wr_en && addr == 3'(RA_BASE))); // R7
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int NCH = 3,
    localparam int NSRC = NCH * CAUSES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [1:0]      rot,
    output logic [NSRC-1:0] grant,
    output logic [3:0]      code
);
    function automatic logic [NSRC-1:0] perr_positions();
        logic [NSRC-1:0] p;
        p = '0;
        for (int c = 0; c < NCH; c++) p[c*CAUSES + int'(CA_PERR)] = 1'b1;
        return p;
    endfunction

    localparam logic [NSRC-1:0] PERR_POS = perr_positions();

    logic found;
    int   first;
    int   idx;

    always_comb begin
        grant = '0;
        code  = 4'hF;
        found = 1'b0;
        first = (int'(rot) < NCH) ? int'(rot) : 0;
        idx   = 0;
        // wrong parity, fixed channel order
        for (int c = 0; c < NCH; c++) begin
            if (!found && pend[c*CAUSES + int'(CA_PERR)]) begin
                found = 1'b1;
                grant[c*CAUSES + int'(CA_PERR)] = 1'b1;
                code  = {2'(c), CA_PERR};
            end
        end
        // data ready, rotated channel order
        for (int k = 0; k < NCH; k++) begin
            idx = first + k;
            if (idx >= NCH) idx = idx - NCH;
            if (!found && pend[idx*CAUSES + int'(CA_READY)]) begin
                found = 1'b1;
                grant[idx*CAUSES + int'(CA_READY)] = 1'b1;
                code  = {2'(idx), CA_READY};
            end
        end
        // end of transmission, fixed channel order
        for (int c = 0; c < NCH; c++) begin
            if (!found && pend[c*CAUSES + int'(CA_EOT)]) begin
                found = 1'b1;
                grant[c*CAUSES + int'(CA_EOT)] = 1'b1;
                code  = {2'(c), CA_EOT};
            end
        end
        // FIFO empty, fixed channel order
        for (int c = 0; c < NCH; c++) begin
            if (!found && pend[c*CAUSES + int'(CA_EMPTY)]) begin
                found = 1'b1;
                grant[c*CAUSES + int'(CA_EMPTY)] = 1'b1;
                code  = {2'(c), CA_EMPTY};
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R8

    AST_PERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & PERR_POS)) |-> (|(grant & PERR_POS))); // R8
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 12,
    parameter int VW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rx_ready_i,
    input  logic [NCH-1:0] rx_perr_i,
    input  logic [NCH-1:0] tx_eot_i,
    input  logic [NCH-1:0] tx_empty_i,
    input  logic           reg_wr_i,
    input  logic [2:0]     reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic           irq_o,
    input  logic           iack_i,
    output logic [VW-1:0]  vector_o
);
    localparam int NSRC = NCH * CAUSES;
    localparam logic [VW-1:0] VEC_DEFAULT = VW'(8'h0F);

    logic [NSRC-1:0] status, mask, pend, grant;
    logic [VW-5:0]   base_hi;
    logic            base_set;
    logic [1:0]      rot;
    logic [3:0]      code;

    ivc_regs #(.NCH(NCH), .DW(DW), .VW(VW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_ready   (rx_ready_i),
        .ev_perr    (rx_perr_i),
        .ev_eot     (tx_eot_i),
        .ev_empty   (tx_empty_i),
        .wr_en      (reg_wr_i),
        .addr       (reg_addr_i),
        .wdata      (reg_wdata_i),
        .rdata      (reg_rdata_o),
        .status_o   (status),
        .mask_o     (mask),
        .base_hi_o  (base_hi),
        .base_set_o (base_set),
        .rot_o      (rot)
    );

    assign pend = status & mask;

    ivc_arbiter #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .rot   (rot),
        .grant (grant),
        .code  (code)
    );

    typedef struct packed {
        logic [VW-1:0] vec;
    } ack_s;

    ack_s a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (iack_i) begin
            a_d.vec = base_set ? {base_hi, code} : VEC_DEFAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q.vec <= VEC_DEFAULT;
        else        a_q     <= a_d;
    end

    assign vector_o = a_q.vec;
    assign irq_o    = |pend;

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(iack_i) |-> $stable(vector_o)); // R6

    AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !base_set |-> (vector_o == VEC_DEFAULT)); // R7

    AST_ACK_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(iack_i) && $past(irq_o) && $past(base_set)) |-> (vector_o[3:0] != 4'hF)); // R6
endmodule

// File: tb/sim_ivc_top.sv
module sim_ivc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rdy = '0, perr = '0, eot = '0, emp = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic [11:0] rdata;
    logic        irq;
    logic        ack = 1'b0;
    logic [7:0]  vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ivc_top u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_ready_i(rdy), .rx_perr_i(perr), .tx_eot_i(eot), .tx_empty_i(emp),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .iack_i(ack), .vector_o(vec)
    );

    // {perr, ready, eot, empty, mask, rot, vector, irq}
    localparam int NV = 12;
    localparam logic [34:0] TBL [NV] = '{
        {3'b000, 3'b111, 3'b000, 3'b000, 12'hFFF, 2'd0, 8'hA0, 1'b1},
        {3'b000, 3'b111, 3'b000, 3'b000, 12'hFFF, 2'd1, 8'hA4, 1'b1},
        {3'b000, 3'b111, 3'b000, 3'b000, 12'hFFF, 2'd2, 8'hA8, 1'b1},
        {3'b000, 3'b111, 3'b000, 3'b000, 12'hFFF, 2'd3, 8'hA0, 1'b1},
        {3'b000, 3'b101, 3'b000, 3'b000, 12'hFFF, 2'd1, 8'hA8, 1'b1},
        {3'b100, 3'b111, 3'b000, 3'b000, 12'hFFF, 2'd0, 8'hA9, 1'b1},
        {3'b000, 3'b000, 3'b110, 3'b001, 12'hFFF, 2'd0, 8'hA6, 1'b1},
        {3'b000, 3'b000, 3'b000, 3'b110, 12'hFFF, 2'd0, 8'hA7, 1'b1},
        {3'b000, 3'b001, 3'b111, 3'b000, 12'hFFE, 2'd0, 8'hA2, 1'b1},
        {3'b111, 3'b111, 3'b111, 3'b111, 12'h000, 2'd0, 8'hAF, 1'b0},
        {3'b011, 3'b000, 3'b000, 3'b000, 12'hFFD, 2'd0, 8'hA5, 1'b1},
        {3'b000, 3'b010, 3'b000, 3'b000, 12'hFFF, 2'd2, 8'hA4, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] r, input logic [2:0] p, input logic [2:0] e,
                       input logic [2:0] m, input logic w, input logic [2:0] a,
                       input logic [11:0] d, input logic k);
        @(negedge clk);
        rdy = r; perr = p; eot = e; emp = m; wr = w; addr = a; wdata = d; ack = k;
        @(posedge clk);
        #1;
        rdy = '0; perr = '0; eot = '0; emp = '0; wr = 1'b0; addr = '0; wdata = '0; ack = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [11:0] d);
        cyc(3'b0, 3'b0, 3'b0, 3'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] v);
        addr = a;
        #0.5;
        v = rdata;
        addr = '0;
    endtask

    task automatic clear_all();
        wreg(3'd0, 12'hFFF);
        wreg(3'd5, 12'hFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 vector", 32'(vec), 32'h0F);
        rd(3'd0, v); chk("R1 status", 32'(v), 0);
        rd(3'd1, v); chk("R1 mask", 32'(v), 0);
        rd(3'd3, v); chk("R1 rotation", 32'(v), 0);
        rd(3'd4, v); chk("R1 selftest", 32'(v), 0);

        // R5 parity ignored while self-test off
        cyc(3'b0, 3'b111, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b0);
        rd(3'd0, v); chk("R5 parity blocked", 32'(v), 0);

        // R2 layout, R3 irq, R7 default vector
        wreg(3'd1, 12'hFFF);
        cyc(3'b010, 3'b0, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b0);
        rd(3'd0, v); chk("R2 ready ch1 bit4", 32'(v), 32'h010);
        chk("R3 irq set", 32'(irq), 1);
        cyc(3'b0, 3'b0, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b1);
        chk("R7 unwritten base vector", 32'(vec), 32'h0F);
        rd(3'd2, v); chk("R7 base reads zero", 32'(v), 0);

        // R4 write-1-to-clear
        wreg(3'd0, 12'h010);
        rd(3'd0, v); chk("R4 cleared", 32'(v), 0);
        chk("R3 irq dropped", 32'(irq), 0);

        // R2 event beats same-cycle clear
        cyc(3'b001, 3'b0, 3'b0, 3'b0, 1'b1, 3'd0, 12'h001, 1'b0);
        rd(3'd0, v); chk("R2 set wins", 32'(v), 32'h001);
        clear_all();

        // R5 parity with self-test on, separate clear
        wreg(3'd4, 12'h001);
        rd(3'd4, v); chk("R10 selftest readback", 32'(v), 1);
        cyc(3'b0, 3'b111, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b0);
        rd(3'd0, v); chk("R5 parity set", 32'(v), 32'h222);
        wreg(3'd0, 12'hFFF);
        rd(3'd0, v); chk("R4 parity survives status clear", 32'(v), 32'h222);
        wreg(3'd5, 12'h020);
        rd(3'd0, v); chk("R5 parity clear one", 32'(v), 32'h202);
        wreg(3'd5, 12'hFFF);
        rd(3'd0, v); chk("R5 parity clear all", 32'(v), 0);

        // R2 end-of-transmission layout
        cyc(3'b0, 3'b0, 3'b100, 3'b0, 1'b0, 3'd0, 12'h0, 1'b0);
        rd(3'd0, v); chk("R2 eot ch2 bit10", 32'(v), 32'h400);
        clear_all();

        // R7 base write-only
        wreg(3'd2, 12'h0A0);
        rd(3'd2, v); chk("R7 base still reads zero", 32'(v), 0);

        // R8 R9 R6 vector table
        for (int i = 0; i < NV; i++) begin
            logic [34:0] e;
            e = TBL[i];
            clear_all();
            wreg(3'd1, e[22:11]);
            wreg(3'd3, {10'd0, e[10:9]});
            cyc(e[31:29], e[34:32], e[28:26], e[25:23], 1'b0, 3'd0, 12'h0, 1'b0);
            chk($sformatf("R3 irq entry %0d", i), 32'(irq), 32'(e[0]));
            cyc(3'b0, 3'b0, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b1);
            chk($sformatf("R8 R9 vector entry %0d", i), 32'(vec), 32'(e[8:1]));
        end
        rd(3'd3, v); chk("R9 rotation readback", 32'(v), 2);

        // R6 vector held until next acknowledge
        clear_all();
        wreg(3'd1, 12'hFFF);
        cyc(3'b0, 3'b001, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b0);
        chk("R6 vector held", 32'(vec), 32'hA4);
        cyc(3'b0, 3'b0, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b1);
        chk("R6 new vector parity ch0", 32'(vec), 32'hA1);
        clear_all();
        cyc(3'b0, 3'b0, 3'b0, 3'b0, 1'b0, 3'd0, 12'h0, 1'b1);
        chk("R6 nothing pending", 32'(vec), 32'hAF);

        // R10 readback and unused addresses
        wreg(3'd1, 12'h5A5);
        rd(3'd1, v); chk("R10 mask readback", 32'(v), 32'h5A5);
        rd(3'd6, v); chk("R10 unused address", 32'(v), 0);
        rd(3'd5, v); chk("R10 parity clear reads zero", 32'(v), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule